// File: doc/BRIEF.md
# Radio Time Frame Decoder

This block checks and unpacks one minute of a long-wave time broadcast once the bits of that minute are held in a 59-bit vector. The vector index is the second number within the minute. When a decode strobe is applied, the block tests the vector against several rules:

- the start-of-time marker must be set;
- three even-parity groups must hold;
- every BCD digit and every calendar field must lie within its legal range.

The block then registers the result: one valid flag and the six decoded fields in plain binary.

A capture stage that samples the radio signal and assembles the bits drives the frame and the strobe. It reads the result on the cycle that the done pulse marks. The field outputs always show what the last strobed frame contained. They are meaningful only when valid is high.

Top module: `tsig_frame_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, done and valid are 0 and every field output is 0.
- R2: A decode strobe high at a clock edge makes done 1 for exactly the following cycle. Valid and all fields update at that same edge. With no strobe, done stays 0 and valid and the fields keep their values whatever frame_in does.
- R3: A frame whose 59 bits are all zero is reported invalid.
- R4: Bit 20 is the start-of-time marker. If it is 0, the frame is invalid.
- R5: Three groups must each hold an even number of ones: bits 21 to 28, bits 29 to 35, and bits 36 to 58. Any odd group makes the frame invalid.
- R6: Each field is a units digit followed by a tens digit, least significant bit first, and is output as a binary value (units + 10 × tens). Minute: units in bits 21–24, tens in 25–27. Hour: units in 29–32, tens in 33–34. Day of month: units in 36–39, tens in 40–41. Weekday: bits 42–44, with 1 meaning Monday. Month: units in 45–48, tens in bit 49. Year: units in 50–53, tens in 54–57.
- R7: The frame is invalid unless minute ≤ 59, hour ≤ 23, day 1–31, weekday 1–7, month 1–12 and year ≤ 99.
- R8: A 4-bit units digit above 9 in minute, hour, day, month or year makes the frame invalid, even when the combined value is in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 59 | Captured minute frame, index = second of the minute |
| decode_go | input | 1 | Strobe: decode frame_in at this edge |
| done | output | 1 | One-cycle pulse: result registers are updated |
| valid | output | 1 | Last decoded frame passed every check |
| minute_o | output | 8 | Decoded minute |
| hour_o | output | 8 | Decoded hour |
| mday_o | output | 8 | Decoded day of month |
| wday_o | output | 8 | Decoded weekday, 1 = Monday |
| month_o | output | 8 | Decoded month |
| year_o | output | 8 | Decoded two-digit year |

## Verification
The assertions assume that frame_in is stable and fully defined at every edge where decode_go is high. The properties that relate done, valid and the fields to the past frame depend on this. The bench drives frame_in and decode_go only at falling clock edges and changes the frame only in cycles without a strobe. When it tests the hold behaviour, it changes frame_in with decode_go low, so the frame-related properties are not triggered by an unstrobed frame.

// File: rtl/tsig_pkg.sv
package tsig_pkg;

    localparam int FRAME_W  = 59;
    localparam int MARK_BIT = 20;
    localparam int NFIELD   = 6;
    localparam int NGROUP   = 3;
    localparam int VAL_W    = 8;

    typedef struct packed {
        logic [VAL_W-1:0] minute;
        logic [VAL_W-1:0] hour;
        logic [VAL_W-1:0] mday;
        logic [VAL_W-1:0] wday;
        logic [VAL_W-1:0] month;
        logic [VAL_W-1:0] year;
    } tsig_time_t;

    // field order: 0 minute, 1 hour, 2 day, 3 weekday, 4 month, 5 year
    function automatic int fld_lsb(input int i);
        case (i)
            0: return 21;  1: return 29;  2: return 36;
            3: return 42;  4: return 45;  default: return 50;
        endcase
    endfunction

    function automatic int fld_units_w(input int i);
        return (i == 3) ? 3 : 4;
    endfunction

    function automatic int fld_tens_w(input int i);
        case (i)
            0: return 3;  1: return 2;  2: return 2;
            3: return 0;  4: return 1;  default: return 4;
        endcase
    endfunction

    function automatic int fld_min(input int i);
        return (i == 2 || i == 3 || i == 4) ? 1 : 0;
    endfunction

    function automatic int fld_max(input int i);
        case (i)
            0: return 59;  1: return 23;  2: return 31;
            3: return 7;   4: return 12;  default: return 99;
        endcase
    endfunction

    function automatic int grp_lo(input int g);
        case (g)
            0: return 21;  1: return 29;  default: return 36;
        endcase
    endfunction

    function automatic int grp_hi(input int g);
        case (g)
            0: return 28;  1: return 35;  default: return 58;
        endcase
    endfunction

endpackage

// File: rtl/tsig_parity_group.sv
module tsig_parity_group #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_i,
    output logic         even_ok
);
    always_comb even_ok = ~(^bits_i);
endmodule

// File: rtl/tsig_bcd_field.sv
module tsig_bcd_field
    import tsig_pkg::*;
#(
    parameter int UW = 4,
    parameter int TW = 3,
    parameter int LO = 0,
    parameter int HI = 59
) (
    input  logic [UW+TW-1:0]  raw_i,
    output logic [VAL_W-1:0]  value_o,
    output logic              ok_o
);
    localparam logic [VAL_W-1:0] LO_V = VAL_W'(LO);
    localparam logic [VAL_W-1:0] HI_V = VAL_W'(HI);

    logic [VAL_W-1:0] units_v;
    logic [VAL_W-1:0] tens_v;
    logic             digit_ok;
    logic             lo_ok;

    always_comb units_v = {{(VAL_W-UW){1'b0}}, raw_i[UW-1:0]};

    generate
        if (TW > 0) begin : g_tens
            always_comb tens_v = {{(VAL_W-TW){1'b0}}, raw_i[UW+TW-1:UW]};
        end else begin : g_no_tens
            always_comb tens_v = '0;
        end

        if (UW == 4) begin : g_digit
            always_comb digit_ok = (raw_i[3:0] <= 4'd9);
        end else begin : g_no_digit
            always_comb digit_ok = 1'b1;
        end

        if (LO > 0) begin : g_lo
            always_comb lo_ok = (value_o >= LO_V);
        end else begin : g_no_lo
            always_comb lo_ok = 1'b1;
        end
    endgenerate

    always_comb value_o = units_v + tens_v * VAL_W'(10);
    always_comb ok_o    = digit_ok && lo_ok && (value_o <= HI_V);

endmodule

// File: rtl/tsig_frame_decoder.sv
module tsig_frame_decoder
    import tsig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               decode_go,
    output logic               done,
    output logic               valid,
    output logic [VAL_W-1:0]   minute_o,
    output logic [VAL_W-1:0]   hour_o,
    output logic [VAL_W-1:0]   mday_o,
    output logic [VAL_W-1:0]   wday_o,
    output logic [VAL_W-1:0]   month_o,
    output logic [VAL_W-1:0]   year_o
);
    logic [VAL_W-1:0]  fld_val [NFIELD];
    logic [NFIELD-1:0] fld_ok;
    logic [NGROUP-1:0] grp_ok;
    logic              frame_good;
    tsig_time_t        time_q;
    logic              done_q;
    logic              valid_q;

    genvar gi;
    generate
        for (gi = 0; gi < NFIELD; gi++) begin : g_fld
            localparam int L  = fld_lsb(gi);
            localparam int UW = fld_units_w(gi);
            localparam int TW = fld_tens_w(gi);
            tsig_bcd_field #(
                .UW(UW), .TW(TW), .LO(fld_min(gi)), .HI(fld_max(gi))
            ) u_fld (
                .raw_i   (frame_in[L +: UW+TW]),
                .value_o (fld_val[gi]),
                .ok_o    (fld_ok[gi])
            );
        end

        for (gi = 0; gi < NGROUP; gi++) begin : g_par
            localparam int PL = grp_lo(gi);
            localparam int PH = grp_hi(gi);
            tsig_parity_group #(.W(PH-PL+1)) u_par (
                .bits_i  (frame_in[PH:PL]),
                .even_ok (grp_ok[gi])
            );
        end
    endgenerate

    always_comb begin
        frame_good = (frame_in != '0) && frame_in[MARK_BIT]
                     && (&grp_ok) && (&fld_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            time_q  <= '0;
        end else begin
            done_q <= decode_go;
            if (decode_go) begin
                valid_q      <= frame_good;
                time_q.minute <= fld_val[0];
                time_q.hour   <= fld_val[1];
                time_q.mday   <= fld_val[2];
                time_q.wday   <= fld_val[3];
                time_q.month  <= fld_val[4];
                time_q.year   <= fld_val[5];
            end
        end
    end

    assign done     = done_q;
    assign valid    = valid_q;
    assign minute_o = time_q.minute;
    assign hour_o   = time_q.hour;
    assign mday_o   = time_q.mday;
    assign wday_o   = time_q.wday;
    assign month_o  = time_q.month;
    assign year_o   = time_q.year;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!done && !valid && minute_o == '0 && year_o == '0));

    // R2
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(decode_go) |-> ($stable(valid) && $stable(minute_o) && $stable(hour_o)
                               && $stable(mday_o) && $stable(year_o)));

    // R3
    zero_frame_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(decode_go) && $past(frame_in) == '0) |-> !valid);

    // R4
    marker_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(decode_go) && !$past(frame_in[MARK_BIT])) |-> !valid);

    // R5
    minute_parity_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(decode_go) && (^$past(frame_in[28:21]))) |-> !valid);

    // R7
    range_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (minute_o <= 8'd59 && hour_o <= 8'd23 && mday_o >= 8'd1
                   && mday_o <= 8'd31 && wday_o >= 8'd1 && wday_o <= 8'd7
                   && month_o >= 8'd1 && month_o <= 8'd12 && year_o <= 8'd99));

endmodule

// File: tb/tsig_frame_decoder_tb.sv
module tsig_frame_decoder_tb_top;
    import tsig_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [FRAME_W-1:0] frame_in = '0;
    logic               decode_go = 1'b0;
    logic               done, valid;
    logic [7:0]         minute_o, hour_o, mday_o, wday_o, month_o, year_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tsig_frame_decoder dut_i (
        .clk(clk), .rst(rst), .frame_in(frame_in), .decode_go(decode_go),
        .done(done), .valid(valid), .minute_o(minute_o), .hour_o(hour_o),
        .mday_o(mday_o), .wday_o(wday_o), .month_o(month_o), .year_o(year_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [FRAME_W-1:0] enc(input logic [7:0] mi, input logic [7:0] hr,
        input logic [7:0] dy, input logic [7:0] wd, input logic [7:0] mo, input logic [7:0] yr);
        logic [FRAME_W-1:0] f = '0;
        f[20]    = 1'b1;
        f[27:21] = mi[6:0];
        f[28]    = ^f[27:21];
        f[34:29] = hr[5:0];
        f[35]    = ^f[34:29];
        f[41:36] = dy[5:0];
        f[44:42] = wd[2:0];
        f[49:45] = mo[4:0];
        f[57:50] = yr;
        f[58]    = ^f[57:36];
        return f;
    endfunction

    task automatic decode(input logic [FRAME_W-1:0] f);
        @(negedge clk);
        frame_in  = f;
        decode_go = 1'b1;
        @(negedge clk);
        decode_go = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 done", done, 0);
        chk("R1 valid", valid, 0);
        chk("R1 minute", minute_o, 0);
        chk("R1 year", year_o, 0);
    endtask

    task automatic t_good_max;
        decode(enc(8'h59, 8'h23, 8'h31, 8'd7, 8'h12, 8'h99));
        chk("R2 done pulse", done, 1);
        chk("R7 valid max", valid, 1);
        chk("R6 minute", minute_o, 59);
        chk("R6 hour", hour_o, 23);
        chk("R6 day", mday_o, 31);
        chk("R6 wday", wday_o, 7);
        chk("R6 month", month_o, 12);
        chk("R6 year", year_o, 99);
        @(negedge clk);
        chk("R2 done drops", done, 0);
    endtask

    task automatic t_good_min;
        decode(enc(8'h00, 8'h00, 8'h01, 8'd1, 8'h01, 8'h00));
        chk("R7 valid min", valid, 1);
        chk("R6 day min", mday_o, 1);
        chk("R6 month min", month_o, 1);
        decode(enc(8'h47, 8'h18, 8'h26, 8'd3, 8'h08, 8'h24));
        chk("R6 valid mid", valid, 1);
        chk("R6 minute mid", minute_o, 47);
        chk("R6 hour mid", hour_o, 18);
        chk("R6 day mid", mday_o, 26);
        chk("R6 year mid", year_o, 24);
    endtask

    task automatic t_hold;
        @(negedge clk);
        frame_in = '0;
        repeat (3) @(negedge clk);
        chk("R2 hold done", done, 0);
        chk("R2 hold valid", valid, 1);
        chk("R2 hold minute", minute_o, 47);
        chk("R2 hold year", year_o, 24);
    endtask

    task automatic t_zero_marker;
        decode('0);
        chk("R3 zero frame", valid, 0);
        decode(enc(8'h10, 8'h10, 8'h10, 8'd2, 8'h10, 8'h10) & ~(59'd1 << 20));
        chk("R4 marker clear", valid, 0);
        chk("R4 fields still load", minute_o, 10);
    endtask

    task automatic t_parity;
        logic [FRAME_W-1:0] g = enc(8'h12, 8'h08, 8'h15, 8'd4, 8'h06, 8'h30);
        decode(g);
        chk("R5 base ok", valid, 1);
        decode(g ^ (59'd1 << 28));
        chk("R5 minute group", valid, 0);
        decode(g ^ (59'd1 << 35));
        chk("R5 hour group", valid, 0);
        decode(g ^ (59'd1 << 58));
        chk("R5 date group", valid, 0);
    endtask

    task automatic t_range;
        decode(enc(8'h60, 8'h00, 8'h01, 8'd1, 8'h01, 8'h00));
        chk("R7 minute 60", valid, 0);
        decode(enc(8'h00, 8'h24, 8'h01, 8'd1, 8'h01, 8'h00));
        chk("R7 hour 24", valid, 0);
        decode(enc(8'h00, 8'h00, 8'h00, 8'd1, 8'h01, 8'h00));
        chk("R7 day 0", valid, 0);
        decode(enc(8'h00, 8'h00, 8'h01, 8'd0, 8'h01, 8'h00));
        chk("R7 wday 0", valid, 0);
        decode(enc(8'h00, 8'h00, 8'h01, 8'd1, 8'h13, 8'h00));
        chk("R7 month 13", valid, 0);
        decode(enc(8'h00, 8'h00, 8'h01, 8'd1, 8'h00, 8'h00));
        chk("R7 month 0", valid, 0);
    endtask

    task automatic t_digit;
        decode(enc(8'h0A, 8'h00, 8'h01, 8'd1, 8'h01, 8'h00));
        chk("R8 minute units A", valid, 0);
        decode(enc(8'h00, 8'h00, 8'h01, 8'd1, 8'h01, 8'h1A));
        chk("R8 year units A", valid, 0);
        decode(enc(8'h00, 8'h00, 8'h0F, 8'd1, 8'h01, 8'h00));
        chk("R8 day units F", valid, 0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good_max();
        t_good_min();
        t_hold();
        t_zero_marker();
        t_parity();
        t_range();
        t_digit();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule